// File: doc/BRIEF.md
# Aperture Address Remapper

The remapper turns device addresses that fall inside one fixed, contiguous aperture into physical addresses. The aperture is cut into 4 KiB pages. Each page owns one slot in a flat translation table. A slot holds a physical page frame and a valid bit. The low twelve bits of a device address pass straight through to the physical address, and the bits above them pick the slot.

Software reaches the table only indirectly, over a small 32-bit register bus. It first writes a device address into a select register, which picks the slot for that page. It then writes or reads a data register to store or fetch that slot. A config register holds a global enable.

A separate translation port takes one device address per request. One cycle later it returns a registered physical address with a valid strobe. If the address is outside the aperture, maps to an empty slot, or arrives while translation is disabled, the port raises a fault and returns a physical address of zero.

Top module: `aperture_remap`

## Requirements
- R1: After reset the enable is 0, every slot is invalid, and the select register holds 0. A config read returns 0, and a translation to any page faults.
- R2: Register byte offsets are 0x0 (config), 0x4 (select) and 0x8 (data). A read returns its data on `reg_rdata` with `reg_rvalid` high in the cycle after `reg_rd`. Any other offset reads 0, and a write to it changes nothing.
- R3: Bit 0 of the config register is the translation enable. A config read returns `{31'b0, enable}`. A config read issued in the cycle right after a write already returns the written value, so the read acts as an ordering barrier.
- R4: Writing a device address to the select register picks slot (address − base) >> 12, whatever its low 12 bits. A select read returns the whole address that was written.
- R5: A slot word has bit 31 as the valid flag and bits [30:12] as the physical frame. A data read returns the stored word with bits [11:0] forced to zero.
- R6: When the select register holds an address outside the aperture, data writes are dropped and data reads return 0.
- R7: An address is inside the aperture when base ≤ address ≤ base + PAGE_CNT×4096 − 1, with both bounds inclusive.
- R8: `tr_valid` rises in the cycle after `tr_req`. On a hit, `tr_pa` = {0, frame bits [30:12], device address bits [11:0]} and `tr_fault` = 0.
- R9: A translation that is outside the aperture, hits an invalid slot, or arrives while the enable is 0 gives `tr_fault` = 1 and `tr_pa` = 0.
- R10: Writing an all-zero word to a slot unmaps its page, so later translations to that page fault and a data read returns 0.
- R11: If a translation and a data write to the same slot happen in the same cycle, the write is stored and the translation returns the old contents. A translation in any later cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| tr_req | input | 1 | Translation request |
| tr_addr | input | 32 | Device address to translate |
| tr_valid | output | 1 | Translation result valid |
| tr_fault | output | 1 | Translation fault |
| tr_pa | output | 32 | Translated physical address |

## Verification
Every slot of a 16-page aperture is filled with a frame computed from its index. Every fifth slot is loaded with its valid bit clear, so hits and invalid-slot faults show up side by side. Each page is then translated at its first byte, its last byte and a middle offset, which separates a wrong slot index from a wrong offset merge.

Addresses one below the base, at the base, at the last byte and one past the end test each inclusive bound on its own. Select addresses just outside the aperture show that dropped writes leave the neighbouring slot untouched.

Further cases each tell apart one kind of fault or one timing choice. Translations with the enable cleared, an unmapped slot, and a data write landing in the same cycle as a translation are checked separately. Back-to-back config write-then-read pairs check the ordering barrier.

// File: rtl/aperture_remap.sv
module aperture_remap #(
  parameter logic [31:0] WIN_BASE = 32'h0010_0000,
  parameter int          PAGE_CNT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rvalid,
  input  logic        tr_req,
  input  logic [31:0] tr_addr,
  output logic        tr_valid,
  output logic        tr_fault,
  output logic [31:0] tr_pa
);
  localparam int         IDX_W   = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1;
  localparam logic [32:0] WIN_END = {1'b0, WIN_BASE} + 33'(PAGE_CNT) * 33'd4096;
  localparam logic [3:0] OFS_CFG = 4'h0;
  localparam logic [3:0] OFS_SEL = 4'h4;
  localparam logic [3:0] OFS_DAT = 4'h8;

  logic        en;
  logic [31:0] sel_addr;
  logic [19:0] tab [PAGE_CNT];

  function automatic logic in_win(input logic [31:0] a);
    return ({1'b0, a} >= {1'b0, WIN_BASE}) && ({1'b0, a} < WIN_END);
  endfunction

  function automatic logic [IDX_W-1:0] page_of(input logic [31:0] a);
    logic [31:0] d;
    d = a - WIN_BASE;
    return d[12 +: IDX_W];
  endfunction

  wire             sel_ok = in_win(sel_addr);
  wire [IDX_W-1:0] sel_idx = page_of(sel_addr);
  wire             tr_ok  = in_win(tr_addr);
  wire [IDX_W-1:0] tr_idx = page_of(tr_addr);
  wire [19:0]      tr_ent = tab[tr_idx];
  wire [19:0]      sel_ent = tab[sel_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en         <= 1'b0;
      sel_addr   <= '0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      tr_valid   <= 1'b0;
      tr_fault   <= 1'b0;
      tr_pa      <= '0;
      for (int i = 0; i < PAGE_CNT; i++) tab[i] <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          OFS_CFG: en <= reg_wdata[0];
          OFS_SEL: sel_addr <= reg_wdata;
          OFS_DAT: if (sel_ok) tab[sel_idx] <= {reg_wdata[31], reg_wdata[30:12]};
          default: ;
        endcase
      end
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          OFS_CFG: reg_rdata <= {31'b0, en};
          OFS_SEL: reg_rdata <= sel_addr;
          OFS_DAT: reg_rdata <= sel_ok ? {sel_ent, 12'h000} : 32'h0;
          default: reg_rdata <= 32'h0;
        endcase
      end
      tr_valid <= tr_req;
      if (tr_req) begin
        if (en && tr_ok && tr_ent[19]) begin
          tr_pa    <= {1'b0, tr_ent[18:0], tr_addr[11:0]};
          tr_fault <= 1'b0;
        end else begin
          tr_pa    <= 32'h0;
          tr_fault <= 1'b1;
        end
      end
    end
  end

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  assert_tvalid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tr_req |=> tr_valid);
  assert_offset_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tr_req |=> (tr_fault || tr_pa[11:0] == $past(tr_addr[11:0])));
  assert_fault_zero_pa_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_fault) |-> (tr_pa == 32'h0));
  assert_disabled_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_req && !en) |=> tr_fault);
  assert_outside_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_req && !tr_ok) |=> tr_fault);
endmodule

// File: tb/sim_aperture_remap.sv
module sim_aperture_remap;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam int          NPG  = 16;
  localparam logic [31:0] ENDX = BASE + NPG * 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        tr_req = 1'b0;
  logic [31:0] tr_addr = '0;
  logic        tr_valid, tr_fault;
  logic [31:0] tr_pa;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_tab [NPG];

  always #5 clk = ~clk;

  aperture_remap #(.WIN_BASE(BASE), .PAGE_CNT(NPG)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .tr_req(tr_req), .tr_addr(tr_addr),
    .tr_valid(tr_valid), .tr_fault(tr_fault), .tr_pa(tr_pa));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic xl(input logic [31:0] a, input string r, input logic [31:0] exp_pa, input logic exp_f);
    @(negedge clk); tr_req = 1'b1; tr_addr = a;
    @(negedge clk); tr_req = 1'b0;
    chk(r, {31'b0, tr_valid}, 32'h1);
    chk(r, {31'b0, tr_fault}, {31'b0, exp_f});
    chk(r, tr_pa, exp_pa);
  endtask

  function automatic logic [31:0] expect_pa(input logic [31:0] a);
    logic [31:0] e;
    if (a < BASE || a >= ENDX) return 32'h0;
    e = exp_tab[(a - BASE) >> 12];
    if (!e[31]) return 32'h0;
    return (e & 32'h7FFF_F000) | (a & 32'hFFF);
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got %08h expected %08h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 outputs idle", {30'b0, reg_rvalid, tr_valid}, 32'h0);
    rd(4'h0, d); chk("R1 cfg reset", d, 32'h0);
    chk("R2 rvalid", {31'b0, reg_rvalid}, 32'h1);
    rd(4'h4, d); chk("R1 sel reset", d, 32'h0);
    rd(4'h8, d); chk("R6 sel out of window after reset", d, 32'h0);
    wr(4'h4, BASE); rd(4'h8, d); chk("R1 slot cleared", d, 32'h0);
    wr(4'h0, 32'h1);
    xl(BASE + 32'h10, "R1 reset slot faults", 32'h0, 1'b1);

    wr(4'h0, 32'h0); rd(4'h0, d); chk("R3 barrier 0", d, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); chk("R3 bit0 only", d, 32'h1);
    wr(4'h0, 32'hFFFF_FFFE); rd(4'h0, d); chk("R3 clear", d, 32'h0);
    wr(4'h0, 32'h1);
    wr(4'hC, 32'h0); rd(4'h0, d); chk("R2 stray write ignored", d, 32'h1);
    rd(4'hC, d); chk("R2 stray read zero", d, 32'h0);
    wr(4'h2, 32'h0); rd(4'h0, d); chk("R2 misaligned write ignored", d, 32'h1);

    for (int i = 0; i < NPG; i++) begin
      logic [31:0] sa, w;
      sa = BASE + i * 4096 + ((i * 37) & 32'hFFF);
      if (i % 5 == 4) w = ((((i * 32'h1357) + 32'h20) & 32'h7FFFF) << 12) | 32'hABC;
      else w = 32'h8000_0000 | ((((i * 32'h1357) + 32'h20) & 32'h7FFFF) << 12) | 32'h5A5;
      exp_tab[i] = w & 32'hFFFF_F000;
      wr(4'h4, sa); rd(4'h4, d); chk("R4 select readback", d, sa);
      wr(4'h8, w);
    end
    for (int i = 0; i < NPG; i++) begin
      wr(4'h4, BASE + i * 4096 + 32'hFFF);
      rd(4'h8, d); chk("R5 slot readback", d, exp_tab[i]);
    end

    for (int i = 0; i < NPG; i++) begin
      logic [31:0] offs [3];
      offs[0] = 32'h0; offs[1] = 32'hFFF; offs[2] = (i * 32'h111) & 32'hFFF;
      for (int k = 0; k < 3; k++) begin
        logic [31:0] a;
        a = BASE + i * 4096 + offs[k];
        if (exp_tab[i][31]) xl(a, "R8 hit", expect_pa(a), 1'b0);
        else xl(a, "R9 invalid slot", 32'h0, 1'b1);
      end
    end

    xl(BASE - 1, "R7 below base", 32'h0, 1'b1);
    xl(BASE, "R7 at base", expect_pa(BASE), 1'b0);
    xl(ENDX - 1, "R7 last byte", expect_pa(ENDX - 1), 1'b0);
    xl(ENDX, "R7 past end", 32'h0, 1'b1);
    xl(32'hFFFF_FFFF, "R9 far outside", 32'h0, 1'b1);

    wr(4'h4, ENDX); wr(4'h8, 32'h8123_4000);
    rd(4'h8, d); chk("R6 outside read", d, 32'h0);
    wr(4'h4, BASE - 1); wr(4'h8, 32'h8123_4000);
    rd(4'h8, d); chk("R6 below read", d, 32'h0);
    wr(4'h4, ENDX - 1); rd(4'h8, d); chk("R6 neighbour intact", d, exp_tab[NPG-1]);
    wr(4'h4, BASE); rd(4'h8, d); chk("R6 first intact", d, exp_tab[0]);

    wr(4'h0, 32'h0);
    xl(BASE + 32'h44, "R9 disabled", 32'h0, 1'b1);
    wr(4'h0, 32'h1);
    xl(BASE + 32'h44, "R3 re-enabled", expect_pa(BASE + 32'h44), 1'b0);

    wr(4'h4, BASE + 32'h123); wr(4'h8, 32'h0); exp_tab[0] = 32'h0;
    xl(BASE + 32'h123, "R10 unmapped", 32'h0, 1'b1);
    rd(4'h8, d); chk("R10 readback", d, 32'h0);

    begin
      logic [31:0] old_pa, a;
      a = BASE + 32'h1000 + 32'h10;
      old_pa = expect_pa(a);
      wr(4'h4, a);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'h8055_5000;
      tr_req = 1'b1; tr_addr = a;
      @(negedge clk);
      reg_wr = 1'b0; tr_req = 1'b0;
      chk("R11 same cycle old", tr_pa, old_pa);
      chk("R11 same cycle fault", {31'b0, tr_fault}, 32'h0);
      exp_tab[1] = 32'h8055_5000;
      xl(a, "R11 next sees new", 32'h0055_5010, 1'b0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule